// File: doc/BRIEF.md
# Bilingual Audio Output Router

This block takes one signed left sample and one signed right sample per valid strobe and distributes them to five registered outputs: a line pair, a headphone pair and a single mono speaker feed. A two-bit listening mode picks one of three arrangements. In stereo, each side keeps its own channel and the speaker gets a mono mix. In main-only, the left channel goes everywhere. In sub-only, the right channel goes everywhere. This suits programme material that carries two languages, one on each channel.

A separate mono-line bit replaces only the line-left output with the mono mix, in any mode. The mono mix is the floor average of the two channels, formed at one extra bit of precision and clamped to the sample width.

Control bits are read in the same cycle as the sample they apply to. Every output, and the output-valid flag, updates one clock after an accepted sample. As a result, no output word ever combines two routings.

Top module: `bilingual_router`

## Requirements
- R1: After reset, `out_valid` is 0 and all five sample outputs are 0, until the first accepted sample.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1, and 0 in the cycle after a cycle with `in_valid` = 0.
- R3: The mono mix equals floor((left + right) / 2), computed in two's complement and clamped to the signed range of `SAMPLE_W`. It never wraps, including when both inputs are at full scale.
- R4: With `listen_mode` = 2'b00 (stereo): line-left and headphone-left carry left, line-right and headphone-right carry right, and the speaker carries the mono mix.
- R5: With `listen_mode` = 2'b01 (main): line-left, line-right, headphone-left, headphone-right and speaker all carry left.
- R6: With `listen_mode` = 2'b10 (sub): all five outputs carry right.
- R7: `listen_mode` = 2'b11 routes exactly as stereo (R4).
- R8: With `mono_line` = 1, line-left carries the mono mix in every mode, and the other four outputs are routed as that mode requires without `mono_line`.
- R9: While `in_valid` = 0, all five outputs hold their values, and changes on the sample or control inputs have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks the input samples and controls as valid this cycle |
| in_left | input | SAMPLE_W | Signed left sample |
| in_right | input | SAMPLE_W | Signed right sample |
| listen_mode | input | 2 | 00 stereo, 01 main, 10 sub, 11 stereo |
| mono_line | input | 1 | 1 puts the mono mix on line-left |
| out_valid | output | 1 | Outputs were updated by the previous accepted sample |
| line_left | output | SAMPLE_W | Line output, left |
| line_right | output | SAMPLE_W | Line output, right |
| hp_left | output | SAMPLE_W | Headphone output, left |
| hp_right | output | SAMPLE_W | Headphone output, right |
| speaker | output | SAMPLE_W | Mono speaker output |

## Verification
Two events can coincide in one cycle: a change of listening mode or mono-line bit, and the arrival of a valid sample. The bench drives back-to-back valid samples and changes the mode on every one of them. It then checks that each registered output word matches the routing presented with its own sample, and that the preceding word is unaffected. It also changes the controls and inputs while `in_valid` is low, and confirms that every output keeps its last value.

// File: rtl/bilingual_router_pkg.sv
package bilingual_router_pkg;

    typedef enum logic [1:0] {
        LISTEN_STEREO = 2'b00,
        LISTEN_MAIN   = 2'b01,
        LISTEN_SUB    = 2'b10,
        LISTEN_ALT    = 2'b11
    } listen_e;

    typedef enum logic [1:0] {
        SRC_LEFT  = 2'b00,
        SRC_RIGHT = 2'b01,
        SRC_MIX   = 2'b10
    } src_e;

    // Output slot order inside the routing vector
    localparam int unsigned SLOT_LINE_L = 0;
    localparam int unsigned SLOT_LINE_R = 1;
    localparam int unsigned SLOT_HP_L   = 2;
    localparam int unsigned SLOT_HP_R   = 3;
    localparam int unsigned SLOT_SPK    = 4;
    localparam int unsigned NUM_SLOTS   = 5;

    // Undefined code 11 folds onto stereo
    function automatic listen_e fold_mode(input logic [1:0] raw);
        case (raw)
            2'b01:   return LISTEN_MAIN;
            2'b10:   return LISTEN_SUB;
            default: return LISTEN_STEREO;
        endcase
    endfunction

endpackage

// File: rtl/router_mix_avg.sv
module router_mix_avg #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic signed [SAMPLE_W-1:0] a_i,
    input  logic signed [SAMPLE_W-1:0] b_i,
    output logic signed [SAMPLE_W-1:0] avg_o
);
    localparam int unsigned WIDE_W = SAMPLE_W + 1;
    localparam logic signed [SAMPLE_W-1:0] MAX_V = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [SAMPLE_W-1:0] MIN_V = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic signed [WIDE_W-1:0] sum_w;
    logic signed [WIDE_W-1:0] half_w;

    always_comb begin
        sum_w  = {a_i[SAMPLE_W-1], a_i} + {b_i[SAMPLE_W-1], b_i};
        half_w = sum_w >>> 1;
        if (half_w[WIDE_W-1] != half_w[WIDE_W-2]) begin
            avg_o = half_w[WIDE_W-1] ? MIN_V : MAX_V;
        end else begin
            avg_o = half_w[SAMPLE_W-1:0];
        end
    end
endmodule

// File: rtl/router_select.sv
module router_select
    import bilingual_router_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic [1:0]                 mode_i,
    input  logic                       mono_line_i,
    input  logic signed [SAMPLE_W-1:0] left_i,
    input  logic signed [SAMPLE_W-1:0] right_i,
    input  logic signed [SAMPLE_W-1:0] mix_i,
    output logic [NUM_SLOTS*SAMPLE_W-1:0] slots_o
);
    listen_e mode_f;
    src_e    src [NUM_SLOTS];

    always_comb begin
        mode_f = fold_mode(mode_i);
        case (mode_f)
            LISTEN_MAIN: begin
                for (int s = 0; s < NUM_SLOTS; s++) src[s] = SRC_LEFT;
            end
            LISTEN_SUB: begin
                for (int s = 0; s < NUM_SLOTS; s++) src[s] = SRC_RIGHT;
            end
            default: begin
                src[SLOT_LINE_L] = SRC_LEFT;
                src[SLOT_HP_L]   = SRC_LEFT;
                src[SLOT_LINE_R] = SRC_RIGHT;
                src[SLOT_HP_R]   = SRC_RIGHT;
                src[SLOT_SPK]    = SRC_MIX;
            end
        endcase
        if (mono_line_i) src[SLOT_LINE_L] = SRC_MIX;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_comb begin
            case (src[g])
                SRC_RIGHT: slots_o[g*SAMPLE_W +: SAMPLE_W] = right_i;
                SRC_MIX:   slots_o[g*SAMPLE_W +: SAMPLE_W] = mix_i;
                default:   slots_o[g*SAMPLE_W +: SAMPLE_W] = left_i;
            endcase
        end
    end
endmodule

// File: rtl/bilingual_router.sv
module bilingual_router
    import bilingual_router_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic [1:0]                 listen_mode,
    input  logic                       mono_line,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] line_left,
    output logic signed [SAMPLE_W-1:0] line_right,
    output logic signed [SAMPLE_W-1:0] hp_left,
    output logic signed [SAMPLE_W-1:0] hp_right,
    output logic signed [SAMPLE_W-1:0] speaker
);
    localparam int unsigned BUS_W = NUM_SLOTS * SAMPLE_W;

    typedef struct packed {
        logic             vld;
        logic [BUS_W-1:0] slots;
    } out_state_t;

    out_state_t state_d;
    out_state_t state_q;

    logic signed [SAMPLE_W-1:0] mix_w;
    logic [BUS_W-1:0]           routed_w;

    router_mix_avg #(.SAMPLE_W(SAMPLE_W)) u_mix (
        .a_i   (in_left),
        .b_i   (in_right),
        .avg_o (mix_w)
    );

    router_select #(.SAMPLE_W(SAMPLE_W)) u_sel (
        .mode_i      (listen_mode),
        .mono_line_i (mono_line),
        .left_i      (in_left),
        .right_i     (in_right),
        .mix_i       (mix_w),
        .slots_o     (routed_w)
    );

    // Controls are consumed with the sample, so a routing change lands on a sample boundary
    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.slots = routed_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.vld;
    assign line_left  = state_q.slots[SLOT_LINE_L*SAMPLE_W +: SAMPLE_W];
    assign line_right = state_q.slots[SLOT_LINE_R*SAMPLE_W +: SAMPLE_W];
    assign hp_left    = state_q.slots[SLOT_HP_L*SAMPLE_W +: SAMPLE_W];
    assign hp_right   = state_q.slots[SLOT_HP_R*SAMPLE_W +: SAMPLE_W];
    assign speaker    = state_q.slots[SLOT_SPK*SAMPLE_W +: SAMPLE_W];
endmodule

// File: rtl/bilingual_router_chk.sv
module bilingual_router_chk #(
    parameter int unsigned SAMPLE_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic signed [SAMPLE_W-1:0] in_left,
    input logic signed [SAMPLE_W-1:0] in_right,
    input logic [1:0]                 listen_mode,
    input logic                       mono_line,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] line_left,
    input logic signed [SAMPLE_W-1:0] line_right,
    input logic signed [SAMPLE_W-1:0] hp_left,
    input logic signed [SAMPLE_W-1:0] hp_right,
    input logic signed [SAMPLE_W-1:0] speaker
);
    logic stereo_w;
    assign stereo_w = (listen_mode == 2'b00) || (listen_mode == 2'b11);

    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && in_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !in_valid |=> !out_valid);

    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !in_valid |=> $stable(line_left) && $stable(line_right)
            && $stable(hp_left) && $stable(hp_right) && $stable(speaker));

    // R4 / R7
    a_r4_stereo_sides: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && in_valid && stereo_w |=> hp_left == $past(in_left)
            && hp_right == $past(in_right) && line_right == $past(in_right));

    // R3: the mix lies between the two inputs
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && in_valid && stereo_w |=>
            ((speaker >= $past(in_left) && speaker <= $past(in_right))
          || (speaker >= $past(in_right) && speaker <= $past(in_left))));

    // R5
    a_r5_main_all_left: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && in_valid && listen_mode == 2'b01 |=> hp_left == $past(in_left)
            && hp_right == $past(in_left) && line_right == $past(in_left)
            && speaker == $past(in_left));

    // R6
    a_r6_sub_all_right: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && in_valid && listen_mode == 2'b10 |=> hp_left == $past(in_right)
            && hp_right == $past(in_right) && line_right == $past(in_right)
            && speaker == $past(in_right));

    // R8
    a_r8_mono_line_stereo: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && in_valid && mono_line && stereo_w |=> line_left == speaker);
    a_r8_plain_line: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && in_valid && !mono_line |=> line_left == hp_left);
endmodule

bind bilingual_router bilingual_router_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/bilingual_router_test.sv
module bilingual_router_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int NV = 12;

    typedef struct packed {
        logic        mono;
        logic [1:0]  mode;
        logic signed [W-1:0] l, r, e_ll, e_lr, e_hl, e_hr, e_sp;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'b00, 16'sd100, -16'sd50, 16'sd100, -16'sd50, 16'sd100, -16'sd50, 16'sd25},
        '{1'b0, 2'b01, 16'sd1234, -16'sd777, 16'sd1234, 16'sd1234, 16'sd1234, 16'sd1234, 16'sd1234},
        '{1'b0, 2'b10, 16'sd1234, -16'sd777, -16'sd777, -16'sd777, -16'sd777, -16'sd777, -16'sd777},
        '{1'b0, 2'b11, -16'sd300, 16'sd500, -16'sd300, 16'sd500, -16'sd300, 16'sd500, 16'sd100},
        '{1'b1, 2'b00, 16'sd10, 16'sd20, 16'sd15, 16'sd20, 16'sd10, 16'sd20, 16'sd15},
        '{1'b1, 2'b01, 16'sd10, 16'sd20, 16'sd15, 16'sd10, 16'sd10, 16'sd10, 16'sd10},
        '{1'b1, 2'b10, 16'sd10, 16'sd20, 16'sd15, 16'sd20, 16'sd20, 16'sd20, 16'sd20},
        '{1'b0, 2'b00, 16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767},
        '{1'b0, 2'b00, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768},
        '{1'b0, 2'b00, 16'sd1, -16'sd2, 16'sd1, -16'sd2, 16'sd1, -16'sd2, -16'sd1},
        '{1'b0, 2'b00, 16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768, -16'sd1},
        '{1'b1, 2'b11, -16'sd100, -16'sd201, -16'sd151, -16'sd201, -16'sd100, -16'sd201, -16'sd151}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_left = '0, in_right = '0;
    logic [1:0] listen_mode = 2'b00;
    logic mono_line = 1'b0;
    logic out_valid;
    logic signed [W-1:0] line_left, line_right, hp_left, hp_right, speaker;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bilingual_router #(.SAMPLE_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .listen_mode(listen_mode), .mono_line(mono_line),
        .out_valid(out_valid), .line_left(line_left), .line_right(line_right),
        .hp_left(hp_left), .hp_right(hp_right), .speaker(speaker)
    );

    task automatic check(input string req, input string what,
                         input logic signed [W-1:0] act, input logic signed [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic mono, input logic [1:0] mode);
        if (mono) return "R8";
        case (mode)
            2'b01: return "R5";
            2'b10: return "R6";
            2'b11: return "R7";
            default: return "R4";
        endcase
    endfunction

    task automatic check_all(input string req, input vec_t v);
        check(req, "line_left",  line_left,  v.e_ll);
        check(req, "line_right", line_right, v.e_lr);
        check(req, "hp_left",    hp_left,    v.e_hl);
        check(req, "hp_right",   hp_right,   v.e_hr);
        check(req, "speaker",    speaker,    v.e_sp);
    endtask

    task automatic present(input vec_t v);
        in_valid = 1'b1;
        in_left = v.l;
        in_right = v.r;
        listen_mode = v.mode;
        mono_line = v.mono;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "out_valid", {15'd0, out_valid}, 16'sd0);
        check("R1", "speaker", speaker, 16'sd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after release", {15'd0, out_valid}, 16'sd0);
        check("R1", "line_left after release", line_left, 16'sd0);

        // Table walk, one isolated sample per vector
        for (int i = 0; i < NV; i++) begin
            present(VEC[i]);
            @(negedge clk);
            in_valid = 1'b0;
            check("R2", "out_valid rises", {15'd0, out_valid}, 16'sd1);
            check_all(tag_of(VEC[i].mono, VEC[i].mode), VEC[i]);
            if (i >= 7 && i <= 10) check("R3", "mix boundary", speaker, VEC[i].e_sp);
            @(negedge clk);
            check("R2", "out_valid drops", {15'd0, out_valid}, 16'sd0);
        end

        // R9: inputs and controls move while invalid; last outputs (VEC[11]) stay
        in_left = 16'sd999; in_right = -16'sd999;
        listen_mode = 2'b10; mono_line = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R9", VEC[11]);
        listen_mode = 2'b01; mono_line = 1'b1;
        @(negedge clk);
        check("R9", "speaker held", speaker, -16'sd151);

        // Mode change on every back-to-back sample
        present(VEC[1]);
        @(negedge clk);
        check_all("R5", VEC[1]);
        present(VEC[6]);
        @(negedge clk);
        check_all("R8", VEC[6]);
        present(VEC[3]);
        @(negedge clk);
        check_all("R7", VEC[3]);
        present(VEC[2]);
        @(negedge clk);
        in_valid = 1'b0;
        check_all("R6", VEC[2]);
        check("R2", "out_valid streaming", {15'd0, out_valid}, 16'sd1);
        @(negedge clk);
        check("R2", "out_valid after stream", {15'd0, out_valid}, 16'sd0);
        check_all("R9", VEC[2]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule